// File: doc/BRIEF.md
# Host Port Tail Tag Processor

This block sits on the two byte streams that join a small switch to its host port. Frames that the host sends toward the switch carry one extra byte at their end. The block removes that byte and decodes it into two fields. The first is a destination override that chooses between the normal address lookup, network port 1, network port 2, or both network ports. The second is a frame priority from 0 to 3. Both fields appear on sideband outputs, together with a strobe, on the cycle that carries the last remaining data byte.

Frames that the switch sends toward the host get one byte appended after their last data byte. That byte tells the host which network port received the frame. The host needs this, for example, to learn where a trapped multicast membership frame came from. The frame check sequence is not recomputed.

A single enable input selects the tagging behaviour. When the enable is low, both directions forward every byte unchanged, one cycle later.

Top module: `hostport_tailtag`

## Requirements
- R1: With tagging enabled, each ingress data byte comes out in order, one cycle after the next ingress byte of the same frame is accepted. Idle cycles between bytes hold it back. Start-of-frame is set only on the first output byte.
- R2: With tagging enabled, the final ingress byte (the one marked end-of-frame) is never output. End-of-frame is set on the output byte that came just before it.
- R3: The ingress tag byte bits [1:0] decode to the destination output: 0 = address lookup, 1 = port 1, 2 = port 2, 3 = ports 1 and 2. The decode strobe is high only on the cycle that carries the output end-of-frame.
- R4: The ingress tag byte bits [3:2] appear on the priority output as an unsigned value 0 to 3, on the cycle of the decode strobe.
- R5: With tagging enabled, an ingress frame of one byte (start and end on the same byte) produces no output byte and no strobe. The error output pulses for exactly one cycle, one cycle after that byte.
- R6: With tagging enabled, each egress byte comes out one cycle after it is accepted. The last data byte comes out with end-of-frame low, and the appended tag byte follows on the next cycle with end-of-frame high.
- R7: The appended egress tag has bit [0] equal to the source-port input sampled with the last data byte (0 = port 1, 1 = port 2). Bits [7:1] are zero.
- R8: With tagging disabled, both directions pass every byte through unchanged with its markers, one cycle later. No tag is removed or added, and the strobe and error outputs stay low.
- R9: During and directly after reset, every valid, strobe and error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | Tail tagging enable for both directions |
| ig_in_valid | input | 1 | Ingress byte from host valid |
| ig_in_data | input | 8 | Ingress byte from host |
| ig_in_sof | input | 1 | Ingress byte is first of frame |
| ig_in_eof | input | 1 | Ingress byte is last of frame |
| ig_out_valid | output | 1 | Ingress byte toward switch valid |
| ig_out_data | output | 8 | Ingress byte toward switch |
| ig_out_sof | output | 1 | Output byte is first of frame |
| ig_out_eof | output | 1 | Output byte is last of frame |
| ig_tag_valid | output | 1 | Decoded tag fields valid |
| ig_dest | output | 2 | Decoded destination override |
| ig_prio | output | 2 | Decoded frame priority |
| ig_err | output | 1 | Short ingress frame seen |
| eg_in_valid | input | 1 | Egress byte from switch valid |
| eg_in_data | input | 8 | Egress byte from switch |
| eg_in_sof | input | 1 | Egress byte is first of frame |
| eg_in_eof | input | 1 | Egress byte is last of frame |
| eg_in_src | input | 1 | Receiving network port of the frame, taken with the last byte |
| eg_out_valid | output | 1 | Egress byte toward host valid |
| eg_out_data | output | 8 | Egress byte toward host |
| eg_out_sof | output | 1 | Output byte is first of frame |
| eg_out_eof | output | 1 | Output byte is last of frame |

## Verification
The assertions rely on three things about the inputs. The egress stream leaves at least one idle cycle after every end-of-frame byte, because the appended tag takes that slot. Every frame begins with a start-of-frame byte. The enable changes only while both streams are idle. The stimulus keeps to all three. It puts one idle cycle after each frame in both directions, drives well-formed frames, and changes the enable only between frames. The directed short-frame and gapped-frame tests respect the same rules.

// File: rtl/tailtag_pkg.sv
package tailtag_pkg;
  localparam int BYTE_W   = 8;
  localparam int DEST_W   = 2;
  localparam int PRIO_W   = 2;
  localparam int DEST_LSB = 0;
  localparam int PRIO_LSB = DEST_LSB + DEST_W;
  localparam int SRC_BIT  = 0;

  typedef enum logic [DEST_W-1:0] {
    DST_LOOKUP = 2'd0,
    DST_PORT1  = 2'd1,
    DST_PORT2  = 2'd2,
    DST_BOTH   = 2'd3
  } dest_e;

  function automatic logic [DEST_W-1:0] tag_dest(input logic [BYTE_W-1:0] t);
    return t[DEST_LSB +: DEST_W];
  endfunction

  function automatic logic [PRIO_W-1:0] tag_prio(input logic [BYTE_W-1:0] t);
    return t[PRIO_LSB +: PRIO_W];
  endfunction

  function automatic logic [BYTE_W-1:0] make_src_tag(input logic src);
    logic [BYTE_W-1:0] t;
    t = '0;
    t[SRC_BIT] = src;
    return t;
  endfunction
endpackage

// File: rtl/tt_ingress_strip.sv
module tt_ingress_strip
  import tailtag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              tag_valid,
  output logic [DEST_W-1:0] dest,
  output logic [PRIO_W-1:0] prio,
  output logic              err,
  output logic              short_ev,
  output logic              tag_ev
);
  logic              have_q;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_sof_q;

  assign short_ev = en && in_valid && in_eof && (in_sof || !have_q);
  assign tag_ev   = en && in_valid && in_eof && !short_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      hold_q     <= '0;
      hold_sof_q <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      tag_valid  <= 1'b0;
      dest       <= '0;
      prio       <= '0;
      err        <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      tag_valid <= 1'b0;
      err       <= 1'b0;
      if (!en) begin
        have_q <= 1'b0;
        if (in_valid) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
          out_sof   <= in_sof;
          out_eof   <= in_eof;
        end
      end else if (in_valid) begin
        if (short_ev) begin
          err    <= 1'b1;
          have_q <= 1'b0;
        end else if (tag_ev) begin
          out_valid <= 1'b1;
          out_data  <= hold_q;
          out_sof   <= hold_sof_q;
          out_eof   <= 1'b1;
          tag_valid <= 1'b1;
          dest      <= tag_dest(in_data);
          prio      <= tag_prio(in_data);
          have_q    <= 1'b0;
        end else begin
          out_valid  <= have_q;
          out_data   <= hold_q;
          out_sof    <= hold_sof_q;
          out_eof    <= 1'b0;
          hold_q     <= in_data;
          hold_sof_q <= in_sof;
          have_q     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tt_egress_append.sv
module tt_egress_append
  import tailtag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_src,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              pend
);
  logic [BYTE_W-1:0] pend_tag_q;
  logic              append_ev;

  assign append_ev = en && in_valid && in_eof && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_tag_q <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
    end else if (pend) begin
      out_valid <= 1'b1;
      out_data  <= pend_tag_q;
      out_sof   <= 1'b0;
      out_eof   <= 1'b1;
      pend      <= 1'b0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sof   <= in_sof;
      out_eof   <= in_eof && !append_ev;
      if (append_ev) begin
        pend       <= 1'b1;
        pend_tag_q <= make_src_tag(in_src);
      end
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hostport_tailtag.sv
module hostport_tailtag
  import tailtag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en,
  input  logic              ig_in_valid,
  input  logic [BYTE_W-1:0] ig_in_data,
  input  logic              ig_in_sof,
  input  logic              ig_in_eof,
  output logic              ig_out_valid,
  output logic [BYTE_W-1:0] ig_out_data,
  output logic              ig_out_sof,
  output logic              ig_out_eof,
  output logic              ig_tag_valid,
  output logic [DEST_W-1:0] ig_dest,
  output logic [PRIO_W-1:0] ig_prio,
  output logic              ig_err,
  input  logic              eg_in_valid,
  input  logic [BYTE_W-1:0] eg_in_data,
  input  logic              eg_in_sof,
  input  logic              eg_in_eof,
  input  logic              eg_in_src,
  output logic              eg_out_valid,
  output logic [BYTE_W-1:0] eg_out_data,
  output logic              eg_out_sof,
  output logic              eg_out_eof
);
  logic ig_short_ev;
  logic ig_tag_ev;
  logic eg_pend;

  tt_ingress_strip u_ing (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tag_en),
    .in_valid (ig_in_valid),
    .in_data  (ig_in_data),
    .in_sof   (ig_in_sof),
    .in_eof   (ig_in_eof),
    .out_valid(ig_out_valid),
    .out_data (ig_out_data),
    .out_sof  (ig_out_sof),
    .out_eof  (ig_out_eof),
    .tag_valid(ig_tag_valid),
    .dest     (ig_dest),
    .prio     (ig_prio),
    .err      (ig_err),
    .short_ev (ig_short_ev),
    .tag_ev   (ig_tag_ev)
  );

  tt_egress_append u_egr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tag_en),
    .in_valid (eg_in_valid),
    .in_data  (eg_in_data),
    .in_sof   (eg_in_sof),
    .in_eof   (eg_in_eof),
    .in_src   (eg_in_src),
    .out_valid(eg_out_valid),
    .out_data (eg_out_data),
    .out_sof  (eg_out_sof),
    .out_eof  (eg_out_eof),
    .pend     (eg_pend)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tailtag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tag_en,
  input logic              ig_in_valid,
  input logic [BYTE_W-1:0] ig_in_data,
  input logic              ig_out_valid,
  input logic [BYTE_W-1:0] ig_out_data,
  input logic              ig_out_eof,
  input logic              ig_tag_valid,
  input logic              ig_err,
  input logic              ig_short_ev,
  input logic              eg_in_valid,
  input logic              eg_in_eof,
  input logic              eg_in_src,
  input logic              eg_out_valid,
  input logic [BYTE_W-1:0] eg_out_data,
  input logic              eg_out_eof,
  input logic              eg_pend
);
  // R3: strobe only together with the output end-of-frame
  p_strobe_eof_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ig_tag_valid |-> (ig_out_valid && ig_out_eof));

  // R5: a short frame raises the error and emits nothing
  p_short_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ig_short_ev |=> (ig_err && !ig_out_valid && !ig_tag_valid));

  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ig_err |=> !ig_err);

  // R6: input assumption, no egress byte while a tag is pending
  p_eg_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eg_pend |-> !eg_in_valid);

  // R6: last byte loses end-of-frame, tag follows with it
  p_eg_append_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en && eg_in_valid && eg_in_eof) |=>
      (eg_out_valid && !eg_out_eof) ##1 (eg_out_valid && eg_out_eof));

  // R7: tag carries the source port in bit 0, zeros above
  p_eg_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_en && eg_in_valid && eg_in_eof) |-> ##2
      (eg_out_data[BYTE_W-1:1] == '0 && eg_out_data[0] == $past(eg_in_src, 2)));

  // R8: bypass forwards every ingress byte one cycle later
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_en && ig_in_valid) |=> (ig_out_valid && ig_out_data == $past(ig_in_data)));

  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_en |=> (!ig_tag_valid && !ig_err));
endmodule

bind hostport_tailtag tt_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tag_en      (tag_en),
  .ig_in_valid (ig_in_valid),
  .ig_in_data  (ig_in_data),
  .ig_out_valid(ig_out_valid),
  .ig_out_data (ig_out_data),
  .ig_out_eof  (ig_out_eof),
  .ig_tag_valid(ig_tag_valid),
  .ig_err      (ig_err),
  .ig_short_ev (ig_short_ev),
  .eg_in_valid (eg_in_valid),
  .eg_in_eof   (eg_in_eof),
  .eg_in_src   (eg_in_src),
  .eg_out_valid(eg_out_valid),
  .eg_out_data (eg_out_data),
  .eg_out_eof  (eg_out_eof),
  .eg_pend     (eg_pend)
);

// File: tb/sim_hostport_tailtag.sv
module sim_hostport_tailtag;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // vector: [23] enable, [22:16] data length, [15:8] tag byte, [0] source port
  localparam logic [23:0] VECS [0:NVEC-1] = '{
    {1'b1, 7'd4,  8'h00, 7'd0, 1'b0},
    {1'b1, 7'd3,  8'h01, 7'd0, 1'b1},
    {1'b1, 7'd5,  8'h06, 7'd0, 1'b0},
    {1'b1, 7'd1,  8'h0B, 7'd0, 1'b1},
    {1'b1, 7'd8,  8'h0F, 7'd0, 1'b0},
    {1'b1, 7'd2,  8'hF4, 7'd0, 1'b1},
    {1'b0, 7'd3,  8'h0E, 7'd0, 1'b1},
    {1'b0, 7'd1,  8'h55, 7'd0, 1'b0},
    {1'b1, 7'd12, 8'h09, 7'd0, 1'b1},
    {1'b1, 7'd6,  8'hA2, 7'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tag_en = 1'b1;
  logic       ig_in_valid = 1'b0, ig_in_sof = 1'b0, ig_in_eof = 1'b0;
  logic [7:0] ig_in_data = '0;
  logic       ig_out_valid, ig_out_sof, ig_out_eof, ig_tag_valid, ig_err;
  logic [7:0] ig_out_data;
  logic [1:0] ig_dest, ig_prio;
  logic       eg_in_valid = 1'b0, eg_in_sof = 1'b0, eg_in_eof = 1'b0, eg_in_src = 1'b0;
  logic [7:0] eg_in_data = '0;
  logic       eg_out_valid, eg_out_sof, eg_out_eof;
  logic [7:0] eg_out_data;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_tailtag u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ibyte(input int v, input int j);
    return 8'(v * 16 + j * 3 + 1);
  endfunction

  function automatic logic [7:0] ebyte(input int v, input int j);
    return 8'(8'hC0 ^ (v * 7 + j * 5));
  endfunction

  task automatic idle_both();
    ig_in_valid = 0; ig_in_sof = 0; ig_in_eof = 0;
    eg_in_valid = 0; eg_in_sof = 0; eg_in_eof = 0;
  endtask

  task automatic run_vec(input int v);
    logic en, src;
    int   len;
    logic [7:0] tg;
    en  = VECS[v][23];
    len = int'(VECS[v][22:16]);
    tg  = VECS[v][15:8];
    src = VECS[v][0];
    tag_en = en;
    for (int j = 0; j <= len; j++) begin
      ig_in_valid = 1; ig_in_data = (j == len) ? tg : ibyte(v, j);
      ig_in_sof = (j == 0); ig_in_eof = (j == len);
      if (j < len) begin
        eg_in_valid = 1; eg_in_data = ebyte(v, j);
        eg_in_sof = (j == 0); eg_in_eof = (j == len - 1); eg_in_src = src;
      end else begin
        eg_in_valid = 0; eg_in_sof = 0; eg_in_eof = 0;
      end
      @(posedge clk); @(negedge clk);
      if (en) begin
        if (j == 0) chk(!ig_out_valid, "R1 held first byte", int'(ig_out_valid), 0);
        else begin
          chk(ig_out_valid && ig_out_data == ibyte(v, j-1), "R1 ingress data",
              int'(ig_out_data), int'(ibyte(v, j-1)));
          chk(ig_out_sof == (j == 1), "R1 ingress sof", int'(ig_out_sof), int'(j == 1));
          chk(ig_out_eof == (j == len), "R2 eof moved", int'(ig_out_eof), int'(j == len));
          chk(ig_tag_valid == (j == len), "R3 strobe", int'(ig_tag_valid), int'(j == len));
          if (j == len) begin
            chk(ig_dest == tg[1:0], "R3 dest", int'(ig_dest), int'(tg[1:0]));
            chk(ig_prio == tg[3:2], "R4 prio", int'(ig_prio), int'(tg[3:2]));
          end
        end
      end else begin
        chk(ig_out_valid && ig_out_data == ((j == len) ? tg : ibyte(v, j)), "R8 ingress bypass",
            int'(ig_out_data), int'((j == len) ? tg : ibyte(v, j)));
        chk(ig_out_eof == (j == len) && !ig_tag_valid && !ig_err, "R8 ingress markers",
            int'({ig_out_eof, ig_tag_valid, ig_err}), int'(j == len) << 2);
      end
      if (j < len) begin
        chk(eg_out_valid && eg_out_data == ebyte(v, j), "R6 egress data",
            int'(eg_out_data), int'(ebyte(v, j)));
        chk(eg_out_eof == (!en && j == len - 1), en ? "R6 egress eof" : "R8 egress eof",
            int'(eg_out_eof), int'(!en && j == len - 1));
        chk(eg_out_sof == (j == 0), "R6 egress sof", int'(eg_out_sof), int'(j == 0));
      end else if (en) begin
        chk(eg_out_valid && eg_out_eof, "R6 tag slot", int'({eg_out_valid, eg_out_eof}), 3);
        chk(eg_out_data == {7'd0, src}, "R7 egress tag", int'(eg_out_data), int'(src));
      end else begin
        chk(!eg_out_valid, "R8 no tag added", int'(eg_out_valid), 0);
      end
    end
    idle_both();
    @(posedge clk); @(negedge clk);
    chk(!ig_out_valid && !eg_out_valid, "R2 idle after frame",
        int'({ig_out_valid, eg_out_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    ig_in_valid = 1; ig_in_sof = 1; ig_in_eof = 1; eg_in_valid = 1;
    @(posedge clk); @(negedge clk);
    chk(!ig_out_valid && !eg_out_valid && !ig_tag_valid && !ig_err, "R9 in reset",
        int'({ig_out_valid, eg_out_valid, ig_tag_valid, ig_err}), 0);
    idle_both();
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    chk(!ig_out_valid && !eg_out_valid && !ig_tag_valid && !ig_err, "R9 after reset",
        int'({ig_out_valid, eg_out_valid, ig_tag_valid, ig_err}), 0);

    for (int v = 0; v < NVEC; v++) run_vec(v);

    // R5: one-byte frame with tagging on
    tag_en = 1;
    ig_in_valid = 1; ig_in_data = 8'h07; ig_in_sof = 1; ig_in_eof = 1;
    @(posedge clk); @(negedge clk);
    idle_both();
    chk(ig_err && !ig_out_valid && !ig_tag_valid, "R5 short frame",
        int'({ig_err, ig_out_valid, ig_tag_valid}), 4);
    @(posedge clk); @(negedge clk);
    chk(!ig_err && !ig_out_valid, "R5 error one cycle", int'({ig_err, ig_out_valid}), 0);

    // R8: one-byte frame with tagging off is forwarded, no error
    tag_en = 0;
    ig_in_valid = 1; ig_in_data = 8'h3C; ig_in_sof = 1; ig_in_eof = 1;
    @(posedge clk); @(negedge clk);
    idle_both();
    chk(!ig_err && ig_out_valid && ig_out_data == 8'h3C && ig_out_eof, "R8 short bypass",
        int'(ig_out_data), 8'h3C);
    @(posedge clk); @(negedge clk);

    // R1: idle gap inside an ingress frame holds the pending byte
    tag_en = 1;
    ig_in_valid = 1; ig_in_data = 8'hA1; ig_in_sof = 1; ig_in_eof = 0;
    @(posedge clk); @(negedge clk);
    chk(!ig_out_valid, "R1 gap first", int'(ig_out_valid), 0);
    ig_in_valid = 0; ig_in_sof = 0;
    @(posedge clk); @(negedge clk);
    chk(!ig_out_valid, "R1 gap hold", int'(ig_out_valid), 0);
    ig_in_valid = 1; ig_in_data = 8'hA2;
    @(posedge clk); @(negedge clk);
    chk(ig_out_valid && ig_out_data == 8'hA1 && ig_out_sof, "R1 gap release",
        int'(ig_out_data), 8'hA1);
    ig_in_data = 8'h0D; ig_in_eof = 1;
    @(posedge clk); @(negedge clk);
    idle_both();
    chk(ig_out_valid && ig_out_data == 8'hA2 && ig_out_eof && ig_tag_valid, "R2 gap end",
        int'(ig_out_data), 8'hA2);
    chk(ig_dest == 2'd1 && ig_prio == 2'd3, "R3 gap tag", int'({ig_dest, ig_prio}), 4'b0111);
    @(posedge clk); @(negedge clk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule